// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into a serial frame on a single output line. The frame layout is chosen per character. The character can be five to nine bits long, a parity bit can be added with even or odd sense, and the frame can end with one or two stop bits. The line rests high between frames. The block takes a character through a valid/ready handshake and reports progress on `busy` and `done`.

The frame can be timed in three ways:

- **Asynchronous mode:** each bit lasts one period of an external single-cycle `baud_tick` pulse.
- **Synchronous master mode:** the block makes its own shift clock by toggling it on every tick.
- **Synchronous slave mode:** a shift clock supplied from outside is passed through a two-flop synchronizer, and its edges are detected on the system clock.

In both synchronous modes a polarity setting picks the shift-clock edge on which the data line changes. The receiver samples on the opposite edge. The block captures the configuration when it accepts a character and holds it until that frame ends.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is high, `busy` is low, `done` is low, and `sclk_out` rests at the inverse of `cfg_pol`.
- R2: Every frame begins with exactly one low start bit. The data bits follow least significant bit first.
- R3: `cfg_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits. Codes 5 to 7 select 9 data bits.
- R4: `cfg_par` = 2'b01 adds an even parity bit, so the data bits plus the parity bit hold an even number of ones. `cfg_par` = 2'b10 adds an odd parity bit. Codes 2'b00 and 2'b11 add none. The parity bit sits between the last data bit and the first stop bit.
- R5: `cfg_stop2` = 0 ends the frame with one high stop bit, and `cfg_stop2` = 1 ends it with two.
- R6: With `cfg_sync` = 0, a character is accepted only in a cycle with `baud_tick` high. Each bit then lasts exactly one tick period, and `txd` changes only on ticked cycles.
- R7: During the cycle that ends the last stop bit, `in_ready` is high. A character accepted in that cycle starts its start bit immediately, with no idle bit between the frames.
- R8: With `cfg_sync` = 1 and `cfg_master` = 1, `sclk_out` toggles on each `baud_tick` during a frame. `txd` changes only together with the edge that returns `sclk_out` to its resting level: rising when `cfg_pol` = 0, falling when `cfg_pol` = 1. Each bit is valid at the opposite edge.
- R9: With `cfg_sync` = 1 and `cfg_master` = 0, `txd` advances on the change edge of `sclk_in` (rising when `cfg_pol` = 0, falling when `cfg_pol` = 1). The effect appears exactly three system clock edges after the `sclk_in` change.
- R10: Changing any configuration input after a character is accepted has no effect on that frame.
- R11: `done` pulses high for one cycle when the last stop bit ends. `busy` falls in the same cycle unless a new character is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 9 | Character to send; bits above the selected length are ignored |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character taken at this clock edge when `in_valid` is high |
| cfg_sync | input | 1 | 0 asynchronous, 1 synchronous |
| cfg_master | input | 1 | In synchronous mode: 1 generate shift clock, 0 follow `sclk_in` |
| cfg_pol | input | 1 | Shift-clock polarity; 0 changes data on the rising edge |
| cfg_len | input | 3 | Character length code |
| cfg_par | input | 2 | Parity code |
| cfg_stop2 | input | 1 | Two stop bits when high |
| baud_tick | input | 1 | Single-cycle bit-rate pulse |
| sclk_in | input | 1 | External shift clock for slave mode |
| txd | output | 1 | Serial data line |
| sclk_out | output | 1 | Generated shift clock |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench does not count the frame length itself. It samples `txd` the way a receiver would, on the opposite edge, tick or shift-clock level, so a wrong bit counter or frame vector shows up within one frame as a missing, extra or misplaced bit. A corrupt end-of-frame decision shows up at once in two ways. Either `done` and the fall of `busy` arrive a bit period early or late, or the next start bit fails to follow directly. Each frame is compared as a whole vector against the expected value built from the requirements. A mistake in the slave synchronizer depth is caught by checking, cycle by cycle, when `busy` falls after the final shift-clock edge.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [8:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       cfg_sync,
  input  logic       cfg_master,
  input  logic       cfg_pol,
  input  logic [2:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop2,
  input  logic       baud_tick,
  input  logic       sclk_in,
  output logic       txd,
  output logic       sclk_out,
  output logic       busy,
  output logic       done
);
  localparam int DMAX = 9;
  localparam int FW   = DMAX + 4;
  localparam int CW   = $clog2(FW + 1);

  logic [FW-1:0] sh, fr;
  logic [CW-1:0] cnt, nq, fl;
  logic          sync_q, mst_q, pol_q, sclk_q;
  logic [2:0]    ss;
  logic [3:0]    dlen;
  logic [DMAX:0] mask;
  logic          par_en, par_bit, s_edge, adv, last, acc;

  assign dlen    = (cfg_len > 3'd4) ? 4'd9 : 4'd5 + {1'b0, cfg_len};
  assign mask    = (10'd1 << dlen) - 10'd1;
  assign par_en  = (cfg_par == 2'b01) || (cfg_par == 2'b10);
  assign par_bit = (^(in_data & mask[DMAX-1:0])) ^ (cfg_par == 2'b10);
  assign fl      = CW'(dlen) + CW'(par_en) + CW'(cfg_stop2) + CW'(2);

  always_comb begin
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DMAX; i++)
      if (i < int'(dlen)) fr[i+1] = in_data[i];
    if (par_en) fr[dlen+4'd1] = par_bit;
  end

  assign s_edge   = pol_q ? (ss[2] & ~ss[1]) : (ss[1] & ~ss[2]);
  assign adv      = busy & (!sync_q ? baud_tick
                          : mst_q ? (baud_tick & (sclk_q == pol_q)) : s_edge);
  assign last     = adv && (cnt == nq - CW'(1));
  assign in_ready = (!busy && (cfg_sync || baud_tick)) || last;
  assign acc      = in_valid & in_ready;
  assign txd      = sh[0];
  assign sclk_out = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; cnt <= '0; nq <= '0; busy <= 1'b0; done <= 1'b0;
      sync_q <= 1'b0; mst_q <= 1'b0; pol_q <= 1'b0; sclk_q <= 1'b1; ss <= '0;
    end else begin
      ss   <= {ss[1:0], sclk_in};
      done <= last;
      if (acc) begin
        sh <= fr; cnt <= '0; nq <= fl; busy <= 1'b1;
        sync_q <= cfg_sync; mst_q <= cfg_master; pol_q <= cfg_pol;
        sclk_q <= ~cfg_pol;
      end else begin
        if (adv) begin
          sh  <= {1'b1, sh[FW-1:1]};
          cnt <= cnt + CW'(1);
          if (last) busy <= 1'b0;
        end
        if (busy && sync_q && mst_q && baud_tick) sclk_q <= ~sclk_q;
        else if (!busy) sclk_q <= ~cfg_pol;
      end
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!txd && busy));
  p_async_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sync_q && !baud_tick) |=> $stable(txd));
  p_master_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sync_q && mst_q && !baud_tick) |=> ($stable(txd) && $stable(sclk_out)));
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acc) |=> ($stable(nq) && $stable(pol_q) && $stable(sync_q)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;
  logic clk = 0, rst_n = 0;
  logic [8:0] in_data = '0;
  logic in_valid = 0, cfg_sync = 0, cfg_master = 0, cfg_pol = 0, cfg_stop2 = 0;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_par = 2'b00;
  logic baud_tick = 0, sclk_in = 1;
  logic in_ready, txd, sclk_out, busy, done;
  int checks = 0, fails = 0;
  int tdiv = 0;

  serial_frame_tx uut (.clk, .rst_n, .in_data, .in_valid, .in_ready, .cfg_sync,
    .cfg_master, .cfg_pol, .cfg_len, .cfg_par, .cfg_stop2, .baud_tick, .sclk_in,
    .txd, .sclk_out, .busy, .done);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void build(input logic [8:0] d, input logic [2:0] lc,
      input logic [1:0] pc, input bit s2, output logic [12:0] f, output int n);
    int len, ones;
    len = (lc > 4) ? 9 : 5 + lc;
    f = '1; f[0] = 1'b0; n = 1; ones = 0;
    for (int i = 0; i < len; i++) begin
      f[n] = d[i]; ones += d[i]; n++;
    end
    if (pc == 2'b01) begin f[n] = ones % 2; n++; end
    else if (pc == 2'b10) begin f[n] = !(ones % 2); n++; end
    n += s2 ? 2 : 1;
  endfunction

  task automatic nclk(input int k);
    repeat (k) @(negedge clk);
    #1;
  endtask

  task automatic accept(input logic [8:0] d);
    in_data = d; in_valid = 1;
    while (!in_ready) nclk(1);
    nclk(1);
    in_valid = 0;
  endtask

  task automatic wait_tick;
    while (!baud_tick) nclk(1);
    nclk(1);
  endtask

  task automatic cap_async(input int n, output logic [12:0] got);
    got = '1; got[0] = txd;
    for (int i = 1; i < n; i++) begin
      wait_tick;
      got[i] = txd;
    end
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {busy, done}, 0);
    chk(sclk_out === 1'b1, "R1 reset sclk idle", sclk_out, 1);
  endtask

  task automatic t_async(input logic [8:0] d, input logic [2:0] lc,
      input logic [1:0] pc, input bit s2, input string req);
    logic [12:0] e, g; int n;
    cfg_sync = 0; cfg_len = lc; cfg_par = pc; cfg_stop2 = s2;
    build(d, lc, pc, s2, e, n);
    accept(d);
    chk(busy === 1'b1, {req, " busy"}, busy, 1);
    cap_async(n, g);
    chk(g === e, {req, " frame"}, g, e);
    wait_tick;
    chk(done === 1'b1 && busy === 1'b0, "R11 end of frame", {done, busy}, 2);
    chk(txd === 1'b1, "R1 idle after frame", txd, 1);
    nclk(1);
    chk(done === 1'b0, "R11 done single cycle", done, 0);
  endtask

  task automatic t_cfg_hold;
    logic [12:0] e, g; int n;
    cfg_sync = 0; cfg_len = 3'd3; cfg_par = 2'b00; cfg_stop2 = 0;
    build(9'h03C, 3'd3, 2'b00, 0, e, n);
    accept(9'h03C);
    cfg_len = 3'd0; cfg_par = 2'b10; cfg_stop2 = 1; cfg_pol = 1;
    cap_async(n, g);
    chk(g === e, "R10 config change ignored", g, e);
    wait_tick;
    chk(busy === 1'b0, "R10 frame length kept", busy, 0);
    cfg_pol = 0;
  endtask

  task automatic t_back2back;
    logic [12:0] e1, e2, g; int n1, n2;
    cfg_sync = 0; cfg_len = 3'd0; cfg_par = 2'b01; cfg_stop2 = 0;
    build(9'h015, 3'd0, 2'b01, 0, e1, n1);
    build(9'h00A, 3'd0, 2'b01, 0, e2, n2);
    accept(9'h015);
    cap_async(n1, g);
    chk(g === e1, "R7 first frame", g, e1);
    in_data = 9'h00A; in_valid = 1;
    while (!baud_tick) nclk(1);
    chk(in_ready === 1'b1 && busy === 1'b1, "R7 ready at last stop end", {in_ready, busy}, 3);
    nclk(1);
    in_valid = 0;
    chk(done === 1'b1 && txd === 1'b0, "R7 next start without idle", {done, txd}, 2);
    cap_async(n2, g);
    chk(g === e2, "R7 second frame", g, e2);
    wait_tick;
    chk(busy === 1'b0, "R11 busy low after second", busy, 0);
  endtask

  task automatic t_master(input bit pol);
    logic [12:0] e, g; int n; logic prev;
    cfg_sync = 1; cfg_master = 1; cfg_pol = pol;
    cfg_len = 3'd2; cfg_par = 2'b10; cfg_stop2 = 1;
    nclk(2);
    chk(sclk_out === ~pol, "R8 master idle level", sclk_out, ~pol);
    build(9'h05A, 3'd2, 2'b10, 1, e, n);
    accept(9'h05A);
    g = '1;
    for (int i = 0; i < n; i++) begin
      do begin prev = sclk_out; nclk(1); end while (!(prev !== pol && sclk_out === pol));
      g[i] = txd;
    end
    chk(g === e, "R8 master frame at sample edges", g, e);
    do nclk(1); while (sclk_out !== ~pol);
    chk(busy === 1'b0 && done === 1'b1, "R8 end on change edge", {busy, done}, 1);
    cfg_sync = 0; cfg_master = 0; cfg_pol = 0;
  endtask

  task automatic t_slave(input bit pol);
    logic [12:0] e, g; int n;
    cfg_sync = 1; cfg_master = 0; cfg_pol = pol;
    cfg_len = 3'd4; cfg_par = 2'b01; cfg_stop2 = 0;
    sclk_in = ~pol;
    nclk(5);
    build(9'h1C3, 3'd4, 2'b01, 0, e, n);
    accept(9'h1C3);
    g = '1;
    for (int i = 0; i < n; i++) begin
      nclk(6); sclk_in = pol;
      nclk(1); g[i] = txd;
      nclk(5); sclk_in = ~pol;
    end
    chk(g === e, "R9 slave frame", g, e);
    nclk(2);
    chk(busy === 1'b1, "R9 not before third edge", busy, 1);
    nclk(1);
    chk(busy === 1'b0, "R9 third edge latency", busy, 0);
    cfg_sync = 0; cfg_pol = 0; sclk_in = 1;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    nclk(3);
    rst_n = 1;
    nclk(1);
    t_reset;
    t_async(9'h0A5, 3'd3, 2'b00, 0, "R2 R3 8 bits no parity");
    t_async(9'h01B, 3'd0, 2'b01, 1, "R4 R5 5 bits even two stop");
    t_async(9'h1C3, 3'd4, 2'b10, 0, "R4 9 bits odd");
    t_async(9'h155, 3'd7, 2'b01, 0, "R3 code 7 as 9 bits");
    t_async(9'h1E6, 3'd1, 2'b11, 1, "R3 R4 R6 6 bits code11 no parity");
    t_cfg_hold;
    t_back2back;
    t_master(0);
    t_master(1);
    t_slave(0);
    t_slave(1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule